// File: doc/BRIEF.md
# Dual-Multiplier Mixing Accumulator

This block forms two signed products from four 12-bit operands, the first pair (A, B) and the second pair (C, D). It can flip the sign of either product, adds both into one 24-bit accumulator and presents a 16-bit window of the result. Each operand lane has its own load enable and its own programmable delay of 1 to 16 clocks. This lets samples that arrive at different times be lined up in front of the multipliers, which suits filter taps and weighted mixes of streams.

A 16-bit chaining input can be added into the top 16 bits of the accumulator, so the upper-word output of one mixer feeds the next one down a chain. Optional rounding trims the sum to 16 significant bits as it is accumulated. The accumulator either keeps summing or is reloaded with the new sum on each clock. Control inputs travel through their own pipeline, so a control applied in the same clock as code-0 operands acts on those operands.

Top module: `mix_dual_mac`

## Requirements
- R1: With accumulation off, the accumulator is loaded with the two's-complement sum A*B + C*D. Operands are signed 12-bit values and each product is sign-extended to 24 bits.
- R2: `neg_ab` high subtracts A*B instead of adding it, and `neg_cd` does the same for C*D. The two act independently.
- R3: With `accum` high, the new products are added to the previous accumulator value. With `accum` low, the previous value is discarded.
- R4: With `round_en` high, 2^7 is added to the sum and accumulator bits 7:0 are then cleared.
- R5: With `cas_en` high, `cas_in` is added as a signed value whose bit 0 lines up with accumulator bit 8. With `cas_en` low, `cas_in` has no effect.
- R6: `sel_hi` high selects accumulator bits 23:8 for `y`. `sel_hi` low selects bits 15:0.
- R7: While a lane's enable is low, its input register keeps its value and changes on that operand pin have no effect.
- R8: An operand applied with delay code k reaches `y` 4+k rising edges later. Code 0 gives 1 clock of operand delay and code 15 gives 16. Control inputs reach `y` 4 edges after they are applied.
- R9: Sums beyond the 24-bit range wrap modulo 2^24.
- R10: `y_oe` follows `oe` with no clock involved.
- R11: A synchronous reset clears every pipeline stage, and `y` reads 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Operand A |
| b_in | input | 12 | Operand B |
| c_in | input | 12 | Operand C |
| d_in | input | 12 | Operand D |
| a_en | input | 1 | Load enable for A |
| b_en | input | 1 | Load enable for B |
| c_en | input | 1 | Load enable for C |
| d_en | input | 1 | Load enable for D |
| a_dly | input | 4 | Delay code for A (k gives k+1 clocks) |
| b_dly | input | 4 | Delay code for B |
| c_dly | input | 4 | Delay code for C |
| d_dly | input | 4 | Delay code for D |
| neg_ab | input | 1 | Subtract A*B |
| neg_cd | input | 1 | Subtract C*D |
| accum | input | 1 | Add to previous accumulator value |
| round_en | input | 1 | Round sum to 16 significant bits |
| cas_in | input | 16 | Chaining input, aligned at bit 8 |
| cas_en | input | 1 | Admit chaining input |
| sel_hi | input | 1 | Select upper 16 bits for output |
| oe | input | 1 | Output enable request |
| y | output | 16 | Registered output word |
| y_oe | output | 1 | Output enable, follows `oe` |

## Verification
The bench aims at rounding exactly at the half point. With a low byte of 0x80 the result must round up and with 0x7F it must round down, so a design that truncates or rounds at the wrong bit gives the wrong upper word. It counts edges through delay codes 0, 5 and 15 and across the switch into and out of accumulation, which exposes a control stage too many or too few, or an off-by-one tap. It drives most-negative operands so that a missing sign extension or a wrong wrap shows up in the upper word. It also checks a negative chaining value and a held lane whose pin keeps changing.

// File: rtl/mix_pkg.sv
package mix_pkg;
   localparam int NUM_LANES = 4;

   typedef enum logic [1:0] {
      LANE_A = 2'd0,
      LANE_B = 2'd1,
      LANE_C = 2'd2,
      LANE_D = 2'd3
   } lane_e;

   typedef struct packed {
      logic accum;
      logic rnd;
      logic casen;
   } acc_ctl_t;
endpackage

// File: rtl/mix_delay_line.sv
module mix_delay_line #(
   parameter int W     = 12,
   parameter int DEPTH = 16,
   localparam int SELW = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [W-1:0]    din,
   input  logic [SELW-1:0] code,
   output logic [W-1:0]    tap
);
   if (DEPTH < 2 || DEPTH != (1 << SELW)) begin : g_bad_depth
      $error("mix_delay_line: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]    stg [DEPTH];
   logic [SELW-1:0] code_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
         stg[0] <= '0;
      end else begin
         code_q <= code;
         if (en) stg[0] <= din;
      end
   end

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[k] <= '0;
         else     stg[k] <= stg[k-1];
      end
   end

   assign tap = stg[code_q];

   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(stg[0]));
endmodule

// File: rtl/mix_product.sv
module mix_product #(
   parameter int DW = 12,
   localparam int PW = 2 * DW
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [DW-1:0] x,
   input  logic signed [DW-1:0] y,
   input  logic                 neg,
   output logic signed [PW-1:0] p
);
   logic signed [PW-1:0] prod;

   always_comb prod = PW'(x) * PW'(y);

   always_ff @(posedge clk) begin
      if (rst)      p <= '0;
      else if (neg) p <= -prod;
      else          p <= prod;
   end

   assert_zero_operand_R1: assert property (@(posedge clk) disable iff (rst)
      (x == '0) |=> (p == '0));
endmodule

// File: rtl/mix_accum.sv
module mix_accum #(
   parameter int PW    = 24,
   parameter int ACC_W = 24,
   parameter int CAS_W = 16,
   parameter int OUT_W = 16,
   localparam int DROP = ACC_W - OUT_W,
   localparam int PAD  = ACC_W - CAS_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [PW-1:0] p1,
   input  logic signed [PW-1:0] p2,
   input  logic [CAS_W-1:0]     cas,
   input  mix_pkg::acc_ctl_t    ctl,
   output logic [ACC_W-1:0]     acc
);
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (DROP - 1);

   logic [ACC_W-1:0] p1x, p2x, casx, base, sum, nxt;

   always_comb begin
      p1x  = ACC_W'(p1);
      p2x  = ACC_W'(p2);
      base = ctl.accum ? acc : '0;
      sum  = base + p1x + p2x + (ctl.rnd ? HALF : '0);
   end

   if (PAD > 0) begin : g_cas_pad
      assign casx = ctl.casen ? {cas, {PAD{1'b0}}} : '0;
   end else begin : g_cas_full
      assign casx = ctl.casen ? cas : '0;
   end

   always_comb begin
      nxt = sum + casx;
      if (ctl.rnd) nxt[DROP-1:0] = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= nxt;
   end

   assert_round_clears_R4: assert property (@(posedge clk) disable iff (rst)
      ctl.rnd |=> (acc[DROP-1:0] == '0));
   assert_accum_keeps_R3: assert property (@(posedge clk) disable iff (rst)
      (ctl.accum && p1 == '0 && p2 == '0 && !ctl.casen && !ctl.rnd) |=> $stable(acc));
endmodule

// File: rtl/mix_dual_mac.sv
module mix_dual_mac #(
   parameter int DW     = 12,
   parameter int ACC_W  = 24,
   parameter int CAS_W  = 16,
   parameter int OUT_W  = 16,
   parameter int MAXDLY = 16,
   localparam int DLY_W = $clog2(MAXDLY),
   localparam int PW    = 2 * DW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DW-1:0]    a_in,
   input  logic [DW-1:0]    b_in,
   input  logic [DW-1:0]    c_in,
   input  logic [DW-1:0]    d_in,
   input  logic             a_en,
   input  logic             b_en,
   input  logic             c_en,
   input  logic             d_en,
   input  logic [DLY_W-1:0] a_dly,
   input  logic [DLY_W-1:0] b_dly,
   input  logic [DLY_W-1:0] c_dly,
   input  logic [DLY_W-1:0] d_dly,
   input  logic             neg_ab,
   input  logic             neg_cd,
   input  logic             accum,
   input  logic             round_en,
   input  logic [CAS_W-1:0] cas_in,
   input  logic             cas_en,
   input  logic             sel_hi,
   input  logic             oe,
   output logic [OUT_W-1:0] y,
   output logic             y_oe
);
   import mix_pkg::*;

   if (ACC_W < PW)     begin : g_bad_acc $error("mix_dual_mac: ACC_W below product width"); end
   if (OUT_W >= ACC_W) begin : g_bad_out $error("mix_dual_mac: OUT_W must be below ACC_W"); end
   if (CAS_W > ACC_W)  begin : g_bad_cas $error("mix_dual_mac: CAS_W exceeds ACC_W"); end

   logic [DW-1:0]    lane_din [NUM_LANES];
   logic             lane_en  [NUM_LANES];
   logic [DLY_W-1:0] lane_dly [NUM_LANES];
   logic [DW-1:0]    lane_tap [NUM_LANES];

   always_comb begin
      lane_din[LANE_A] = a_in;  lane_en[LANE_A] = a_en;  lane_dly[LANE_A] = a_dly;
      lane_din[LANE_B] = b_in;  lane_en[LANE_B] = b_en;  lane_dly[LANE_B] = b_dly;
      lane_din[LANE_C] = c_in;  lane_en[LANE_C] = c_en;  lane_dly[LANE_C] = c_dly;
      lane_din[LANE_D] = d_in;  lane_en[LANE_D] = d_en;  lane_dly[LANE_D] = d_dly;
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      mix_delay_line #(.W(DW), .DEPTH(MAXDLY)) u_dly (
         .clk (clk),
         .rst (rst),
         .en  (lane_en[i]),
         .din (lane_din[i]),
         .code(lane_dly[i]),
         .tap (lane_tap[i])
      );
   end

   // control pipeline: stage 0 feeds the multipliers, stage 1 the accumulator,
   // stage 2 the output word select
   logic [1:0]       neg0;
   acc_ctl_t         actl0, actl1;
   logic [CAS_W-1:0] cas0, cas1;
   logic             sel0, sel1, sel2;

   always_ff @(posedge clk) begin
      if (rst) begin
         neg0  <= '0;
         actl0 <= '0;
         actl1 <= '0;
         cas0  <= '0;
         cas1  <= '0;
         sel0  <= 1'b0;
         sel1  <= 1'b0;
         sel2  <= 1'b0;
      end else begin
         neg0  <= {neg_cd, neg_ab};
         actl0 <= '{accum: accum, rnd: round_en, casen: cas_en};
         actl1 <= actl0;
         cas0  <= cas_in;
         cas1  <= cas0;
         sel0  <= sel_hi;
         sel1  <= sel0;
         sel2  <= sel1;
      end
   end

   logic signed [PW-1:0] prod_ab, prod_cd;

   mix_product #(.DW(DW)) u_mul_ab (
      .clk(clk), .rst(rst),
      .x(lane_tap[LANE_A]), .y(lane_tap[LANE_B]),
      .neg(neg0[0]), .p(prod_ab)
   );

   mix_product #(.DW(DW)) u_mul_cd (
      .clk(clk), .rst(rst),
      .x(lane_tap[LANE_C]), .y(lane_tap[LANE_D]),
      .neg(neg0[1]), .p(prod_cd)
   );

   logic [ACC_W-1:0] acc;

   mix_accum #(.PW(PW), .ACC_W(ACC_W), .CAS_W(CAS_W), .OUT_W(OUT_W)) u_acc (
      .clk(clk), .rst(rst),
      .p1(prod_ab), .p2(prod_cd),
      .cas(cas1), .ctl(actl1),
      .acc(acc)
   );

   always_ff @(posedge clk) begin
      if (rst)       y <= '0;
      else if (sel2) y <= acc[ACC_W-1 -: OUT_W];
      else           y <= acc[OUT_W-1:0];
   end

   assign y_oe = oe;

   assert_sel_upper_R6: assert property (@(posedge clk) disable iff (rst)
      sel2 |=> (y == $past(acc[ACC_W-1 -: OUT_W])));
   assert_sel_lower_R6: assert property (@(posedge clk) disable iff (rst)
      !sel2 |=> (y == $past(acc[OUT_W-1:0])));
   assert_reset_clears_R11: assert property (@(posedge clk)
      rst |=> (y == '0));
endmodule

// File: tb/mix_dual_mac_bench.sv
`timescale 1ns/1ps
module mix_dual_mac_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] a_in = '0, b_in = '0, c_in = '0, d_in = '0;
   logic        a_en = 1'b1, b_en = 1'b1, c_en = 1'b1, d_en = 1'b1;
   logic [3:0]  a_dly = '0, b_dly = '0, c_dly = '0, d_dly = '0;
   logic        neg_ab = 1'b0, neg_cd = 1'b0, accum = 1'b0, round_en = 1'b0;
   logic [15:0] cas_in = '0;
   logic        cas_en = 1'b0, sel_hi = 1'b0, oe = 1'b0;
   logic [15:0] y;
   logic        y_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mix_dual_mac u_mix_dual_mac (
      .clk(clk), .rst(rst),
      .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
      .a_en(a_en), .b_en(b_en), .c_en(c_en), .d_en(d_en),
      .a_dly(a_dly), .b_dly(b_dly), .c_dly(c_dly), .d_dly(d_dly),
      .neg_ab(neg_ab), .neg_cd(neg_cd), .accum(accum), .round_en(round_en),
      .cas_in(cas_in), .cas_en(cas_en), .sel_hi(sel_hi), .oe(oe),
      .y(y), .y_oe(y_oe)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] ref_mix(input int a, input int b, input int c, input int d,
                                           input bit n1, input bit n2);
      int p1 = a * b;
      int p2 = c * d;
      if (n1) p1 = -p1;
      if (n2) p2 = -p2;
      return 24'(p1 + p2);
   endfunction

   task automatic set_ops(input int a, input int b, input int c, input int d);
      a_in = 12'(a); b_in = 12'(b); c_in = 12'(c); d_in = 12'(d);
   endtask

   task automatic t_reset;
      check("R11 reset", y, 16'h0000);
   endtask

   task automatic t_products;
      logic [23:0] e;
      set_ops(3, 5, -7, 11); step(20);
      e = ref_mix(3, 5, -7, 11, 0, 0);
      check("R1 lower word", y, e[15:0]);
      sel_hi = 1'b1; step(6);
      check("R6 upper word", y, e[23:8]);
      sel_hi = 1'b0;
      set_ops(100, -200, 50, 40); step(20);
      e = ref_mix(100, -200, 50, 40, 0, 0);
      check("R1 mixed signs", y, e[15:0]);
      sel_hi = 1'b1; step(6);
      check("R6 upper mixed", y, e[23:8]);
      sel_hi = 1'b0;
   endtask

   task automatic t_neg;
      logic [23:0] e;
      set_ops(30, 7, 9, 4);
      neg_ab = 1'b1; step(20);
      e = ref_mix(30, 7, 9, 4, 1, 0);
      check("R2 negate first", y, e[15:0]);
      neg_ab = 1'b0; neg_cd = 1'b1; step(20);
      e = ref_mix(30, 7, 9, 4, 0, 1);
      check("R2 negate second", y, e[15:0]);
      neg_ab = 1'b1; step(20);
      e = ref_mix(30, 7, 9, 4, 1, 1);
      check("R2 negate both", y, e[15:0]);
      neg_ab = 1'b0; neg_cd = 1'b0;
   endtask

   task automatic t_wrap;
      sel_hi = 1'b1;
      set_ops(-2048, -2048, 0, 0); step(20);
      check("R9 single max product", y, 16'h4000);
      set_ops(-2048, -2048, -2048, -2048); step(20);
      check("R9 wrap upper", y, 16'h8000);
      sel_hi = 1'b0; step(6);
      check("R9 wrap lower", y, 16'h0000);
   endtask

   task automatic t_accum;
      set_ops(3, 4, 0, 0); step(20);
      check("R3 pass-through", y, 16'd12);
      accum = 1'b1;
      step(3);
      check("R8 control not yet at output", y, 16'd12);
      step(1);
      check("R3 accumulate 2x", y, 16'd24);
      step(1);
      check("R3 accumulate 3x", y, 16'd36);
      step(1);
      check("R3 accumulate 4x", y, 16'd48);
      accum = 1'b0;
      step(4);
      check("R3 reload", y, 16'd12);
   endtask

   task automatic t_round;
      sel_hi = 1'b1;
      set_ops(1, 128, 0, 0); step(20);
      check("R4 no rounding upper", y, 16'h0000);
      round_en = 1'b1; step(20);
      check("R4 half rounds up", y, 16'h0001);
      sel_hi = 1'b0; step(6);
      check("R4 low byte cleared", y, 16'h0100);
      sel_hi = 1'b1;
      set_ops(1, 127, 0, 0); step(20);
      check("R4 below half rounds down", y, 16'h0000);
      round_en = 1'b0; sel_hi = 1'b0;
   endtask

   task automatic t_cascade;
      set_ops(1, 5, 0, 0);
      cas_in = 16'h0010; cas_en = 1'b0; step(20);
      check("R5 cascade gated off", y, 16'h0005);
      cas_en = 1'b1; step(20);
      check("R5 cascade at bit 8", y, 16'h1005);
      cas_in = 16'hFFFF; step(20);
      check("R5 negative cascade", y, 16'hFF05);
      cas_en = 1'b0; cas_in = '0;
   endtask

   task automatic t_hold;
      set_ops(3, 4, 0, 0); step(20);
      a_en = 1'b0; a_in = 12'd9; step(25);
      check("R7 held lane ignores pin", y, 16'd12);
      a_en = 1'b1; step(20);
      check("R7 lane reloads", y, 16'd36);
   endtask

   task automatic t_latency(input logic [3:0] code);
      a_dly = code;
      set_ops(2, 4, 0, 0); step(40);
      a_in = 12'd3;
      step(3 + int'(code));
      check("R8 old value before delay", y, 16'd8);
      step(1);
      check("R8 new value after delay", y, 16'd12);
      a_dly = '0; step(20);
   endtask

   task automatic t_oe;
      oe = 1'b1; #1;
      check("R10 enable high", {15'd0, y_oe}, 16'd1);
      oe = 1'b0; #1;
      check("R10 enable low", {15'd0, y_oe}, 16'd0);
   endtask

   initial begin
      step(3);
      t_reset();
      rst = 1'b0;
      step(1);
      t_products();
      t_neg();
      t_wrap();
      t_accum();
      t_round();
      t_cascade();
      t_hold();
      t_latency(4'd0);
      t_latency(4'd5);
      t_latency(4'd15);
      t_oe();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule